// File: doc/BRIEF.md
# Multi-Converter Write Strobe Controller

This block sits between a simple processor-style write port and a group of double-buffered digital-to-analog converters. Each converter has two registers. The first holds the next code, and the second drives the analog output. Software loads each converter's first register through a private address. It then writes one shared commit address, and every converter moves its held code to its output in the same instant.

The converters need level-sensitive strobes. Each strobe must stay low for a minimum time, and the data must stay valid on the bus for a further short time after the strobe rises. The controller meets both rules by stretching each access with wait states. The minimum width and the hold time are given in nanoseconds and rounded up to whole cycles of the configured clock period. A global latch-enable output lets the system freeze every converter's first register, so another bus master can reuse the same addresses without disturbing anything.

Top module: `dac_strobe_ctrl`

## Requirements
- R1: After reset, bus_ready is 1, every conv_sel_n bit, load_stb_n, commit_en_n and commit_stb_n are 1, latch_en is 1, dac_data is 0 and dac_pending is 0.
- R2: A write is accepted on a clock edge where bus_wr and bus_ready are both 1. A write to address LOAD_BASE+i (i below NUM_DEV) drives only conv_sel_n[i] and load_stb_n low, starting the cycle after acceptance, with the written byte on dac_data. At most one select bit is ever low.
- R3: A write to COMMIT_ADDR drives commit_en_n and commit_stb_n low together, and no select bit goes low.
- R4: Every strobe stays low for exactly ceil(STROBE_NS/CLK_NS) cycles, which is 45 at the default setting.
- R5: After the strobe rises, bus_ready stays 0 for exactly ceil(HOLD_NS/CLK_NS) cycles (minimum 1), which is 3 at the default setting. dac_data keeps the written value until the next accepted load write, whatever the bus does.
- R6: bus_ready is 0 from the cycle after a mapped write is accepted until the hold count ends. Requests made while bus_ready is 0 are not accepted and cause no strobe.
- R7: A write to any other address is accepted with no wait state (bus_ready stays 1) and drives no strobe.
- R8: An accepted, unfrozen load sets dac_pending[i] one cycle later. An accepted commit clears all of dac_pending. After a commit, only converters loaded since the previous commit show new output values.
- R9: latch_en equals the inverse of freeze, one cycle later. A load write accepted while freeze is 1 is acknowledged with no wait state and no strobe, and dac_pending does not change.
- R10: dac_data is stable over the whole low period of any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write request |
| bus_ready | output | 1 | High when a request can be accepted; low during wait states |
| freeze | input | 1 | Freezes all converter input registers |
| dac_data | output | DATA_W | Data bus to the converters |
| conv_sel_n | output | NUM_DEV | Per-converter select, active low |
| load_stb_n | output | 1 | Shared input-register load strobe, active low |
| commit_en_n | output | 1 | Shared commit enable, active low |
| commit_stb_n | output | 1 | Shared commit strobe, active low |
| latch_en | output | 1 | Global input-latch enable, active high |
| dac_pending | output | NUM_DEV | Converters loaded since the last commit |

## Verification
Several rules are checked on every cycle: that at most one converter is selected, that a commit never overlaps a select, that data stays stable while a strobe is low, and that every strobe is low while bus_ready is low. Strobe width and hold length are measured with counters and compared at each rising edge. The pending flags, the latch enable and the zero-wait completion of unmapped writes are also checked each cycle. Some behaviour only the bench scenarios can show. A behavioural converter model is used to show which outputs change after a commit. Other scenarios show that requests made while busy are dropped, and that a frozen load leaves a converter's held code untouched.

// File: rtl/dac_strobe_pkg.sv
package dac_strobe_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_HOLD   = 2'd2
    } phase_e;

    // Whole cycles covering a time in ns, rounded up, minimum one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction
endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
    parameter int NUM_DEV     = 4,
    parameter int ADDR_W      = 4,
    parameter int LOAD_BASE   = 4,
    parameter int COMMIT_ADDR = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_DEV-1:0] load_hit,
    output logic               commit_hit
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_load
        assign load_hit[i] = (addr == ADDR_W'(LOAD_BASE + i));
    end
    assign commit_hit = (addr == ADDR_W'(COMMIT_ADDR));
endmodule

// File: rtl/dac_pending_track.sv
module dac_pending_track #(
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEV-1:0] set_vec,
    input  logic               clear_all,
    output logic [NUM_DEV-1:0] pending
);
    logic [NUM_DEV-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clear_all) pend_d = '0;
        else           pend_d = pend_q | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;
endmodule

// File: rtl/dac_strobe_ctrl.sv
module dac_strobe_ctrl
    import dac_strobe_pkg::*;
#(
    parameter int NUM_DEV     = 4,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int LOAD_BASE   = 4,
    parameter int COMMIT_ADDR = 12,
    parameter int CLK_NS      = 20,
    parameter int STROBE_NS   = 900,
    parameter int HOLD_NS     = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_wr,
    output logic               bus_ready,
    input  logic               freeze,
    output logic [DATA_W-1:0]  dac_data,
    output logic [NUM_DEV-1:0] conv_sel_n,
    output logic               load_stb_n,
    output logic               commit_en_n,
    output logic               commit_stb_n,
    output logic               latch_en,
    output logic [NUM_DEV-1:0] dac_pending
);
    localparam int STROBE_CYC = ns_to_cycles(STROBE_NS, CLK_NS);
    localparam int HOLD_CYC   = ns_to_cycles(HOLD_NS, CLK_NS);
    localparam int MAX_CYC    = (STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  data;
        logic [NUM_DEV-1:0] sel_n;
        logic               load_n;
        logic               cen_n;
        logic               cstb_n;
        logic               len;
    } ctrl_t;

    ctrl_t              st_d, st_q;
    logic [NUM_DEV-1:0] load_hit;
    logic               commit_hit;
    logic [NUM_DEV-1:0] pend_set;
    logic               pend_clr;

    dac_addr_decode #(
        .NUM_DEV    (NUM_DEV),
        .ADDR_W     (ADDR_W),
        .LOAD_BASE  (LOAD_BASE),
        .COMMIT_ADDR(COMMIT_ADDR)
    ) u_dec (
        .addr      (bus_addr),
        .load_hit  (load_hit),
        .commit_hit(commit_hit)
    );

    dac_pending_track #(.NUM_DEV(NUM_DEV)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (pend_set),
        .clear_all(pend_clr),
        .pending  (dac_pending)
    );

    always_comb begin
        st_d     = st_q;
        pend_set = '0;
        pend_clr = 1'b0;
        st_d.len = ~freeze;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (bus_wr) begin
                    if (commit_hit) begin
                        st_d.phase  = PH_STROBE;
                        st_d.cnt    = CNT_W'(STROBE_CYC - 1);
                        st_d.cen_n  = 1'b0;
                        st_d.cstb_n = 1'b0;
                        pend_clr    = 1'b1;
                    end else if ((|load_hit) && !freeze) begin
                        st_d.phase  = PH_STROBE;
                        st_d.cnt    = CNT_W'(STROBE_CYC - 1);
                        st_d.data   = bus_wdata;
                        st_d.sel_n  = ~load_hit;
                        st_d.load_n = 1'b0;
                        pend_set    = load_hit;
                    end
                    // unmapped or frozen load: completes here, no strobe
                end
            end
            PH_STROBE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase  = PH_HOLD;
                    st_d.cnt    = CNT_W'(HOLD_CYC - 1);
                    st_d.sel_n  = '1;
                    st_d.load_n = 1'b1;
                    st_d.cen_n  = 1'b1;
                    st_d.cstb_n = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) st_d.phase = PH_IDLE;
                else                st_d.cnt   = st_q.cnt - 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.cnt    <= '0;
            st_q.data   <= '0;
            st_q.sel_n  <= '1;
            st_q.load_n <= 1'b1;
            st_q.cen_n  <= 1'b1;
            st_q.cstb_n <= 1'b1;
            st_q.len    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_ready    = (st_q.phase == PH_IDLE);
    assign dac_data     = st_q.data;
    assign conv_sel_n   = st_q.sel_n;
    assign load_stb_n   = st_q.load_n;
    assign commit_en_n  = st_q.cen_n;
    assign commit_stb_n = st_q.cstb_n;
    assign latch_en     = st_q.len;
endmodule

// File: rtl/dac_strobe_chk.sv
module dac_strobe_chk
    import dac_strobe_pkg::*;
#(
    parameter int NUM_DEV     = 4,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int LOAD_BASE   = 4,
    parameter int COMMIT_ADDR = 12,
    parameter int CLK_NS      = 20,
    parameter int STROBE_NS   = 900,
    parameter int HOLD_NS     = 50
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_ready,
    input logic               freeze,
    input logic [DATA_W-1:0]  dac_data,
    input logic [NUM_DEV-1:0] conv_sel_n,
    input logic               load_stb_n,
    input logic               commit_en_n,
    input logic               commit_stb_n,
    input logic               latch_en,
    input logic [NUM_DEV-1:0] dac_pending
);
    localparam int WIDTH_EXP = ns_to_cycles(STROBE_NS, CLK_NS);
    localparam int HOLD_EXP  = ns_to_cycles(HOLD_NS, CLK_NS);

    logic        any_low;
    logic        mapped;
    logic [15:0] low_run;
    logic [15:0] hold_run;

    assign any_low = !load_stb_n || !commit_stb_n;
    assign mapped  = (int'(bus_addr) == COMMIT_ADDR) ||
                     ((int'(bus_addr) >= LOAD_BASE) && (int'(bus_addr) < LOAD_BASE + NUM_DEV));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= '0;
            hold_run <= '0;
        end else begin
            low_run  <= any_low ? low_run + 16'd1 : 16'd0;
            hold_run <= (!bus_ready && !any_low) ? hold_run + 16'd1 : 16'd0;
        end
    end

    p_one_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~conv_sel_n));

    p_commit_no_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en_n |-> (conv_sel_n == '1));

    p_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load_stb_n) || $rose(commit_stb_n)) |-> (low_run == 16'(WIDTH_EXP)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> (hold_run == 16'(HOLD_EXP)));

    p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_low |-> !bus_ready);

    p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ready && !mapped) |=> (bus_ready && !any_low));

    p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb_n |-> (dac_pending == '0));

    p_latch_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !latch_en);

    p_latch_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> latch_en);

    p_data_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb_n && $past(!load_stb_n)) |-> $stable(dac_data));
endmodule

bind dac_strobe_ctrl dac_strobe_chk #(
    .NUM_DEV    (NUM_DEV),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LOAD_BASE  (LOAD_BASE),
    .COMMIT_ADDR(COMMIT_ADDR),
    .CLK_NS     (CLK_NS),
    .STROBE_NS  (STROBE_NS),
    .HOLD_NS    (HOLD_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_ready   (bus_ready),
    .freeze      (freeze),
    .dac_data    (dac_data),
    .conv_sel_n  (conv_sel_n),
    .load_stb_n  (load_stb_n),
    .commit_en_n (commit_en_n),
    .commit_stb_n(commit_stb_n),
    .latch_en    (latch_en),
    .dac_pending (dac_pending)
);

// File: tb/dac_strobe_ctrl_test.sv
`timescale 1ns/1ps
module dac_strobe_ctrl_test;
    localparam int LB = 4;
    localparam int CA = 12;
    localparam int W_EXP = 45;
    localparam int H_EXP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       freeze = 1'b0;
    logic       bus_ready;
    logic [7:0] dac_data;
    logic [3:0] conv_sel_n;
    logic       load_stb_n, commit_en_n, commit_stb_n, latch_en;
    logic [3:0] dac_pending;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    dac_strobe_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_ready(bus_ready), .freeze(freeze),
        .dac_data(dac_data), .conv_sel_n(conv_sel_n), .load_stb_n(load_stb_n),
        .commit_en_n(commit_en_n), .commit_stb_n(commit_stb_n),
        .latch_en(latch_en), .dac_pending(dac_pending)
    );

    always #10 clk = ~clk;

    // Behavioural converter model, sampled at falling edges
    logic [7:0] in_reg [4];
    logic [7:0] out_reg[4];
    logic       p_load = 1'b1, p_cstb = 1'b1, p_cen = 1'b1, p_len = 1'b1;
    logic [3:0] p_sel = 4'hF;
    logic [7:0] p_data = '0;

    initial for (int i = 0; i < 4; i++) begin in_reg[i] = '0; out_reg[i] = '0; end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!p_load && load_stb_n)
                for (int i = 0; i < 4; i++) if (!p_sel[i] && p_len) in_reg[i] = p_data;
            if (!p_cstb && commit_stb_n && !p_cen)
                for (int i = 0; i < 4; i++) out_reg[i] = in_reg[i];
        end
        p_load = load_stb_n; p_cstb = commit_stb_n; p_cen = commit_en_n;
        p_sel = conv_sel_n; p_len = latch_en; p_data = dac_data;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issues one write and observes the whole access
    task automatic do_write(input logic [3:0] a, input logic [7:0] d,
                            output int lc, output int hc, output logic [3:0] selm,
                            output bit ld, output bit cm, output bit dbad);
        logic [7:0] seen;
        bit first;
        while (!bus_ready) @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = ~d;
        lc = 0; hc = 0; selm = '0; ld = 0; cm = 0; dbad = 0; first = 1; seen = '0;
        while (!bus_ready) begin
            if (first) begin seen = dac_data; first = 0; end
            else if (dac_data != seen) dbad = 1;
            if (!load_stb_n || !commit_stb_n) lc++; else hc++;
            selm |= ~conv_sel_n;
            ld |= !load_stb_n;
            cm |= (!commit_stb_n && !commit_en_n);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(bus_ready == 1, "R1 ready", bus_ready, 1);
        chk(conv_sel_n == 4'hF && load_stb_n && commit_en_n && commit_stb_n,
            "R1 strobes idle", {conv_sel_n, load_stb_n, commit_en_n, commit_stb_n}, 127);
        chk(latch_en == 1, "R1 latch_en", latch_en, 1);
        chk(dac_data == 0 && dac_pending == 0, "R1 data/pending", {dac_data, dac_pending}, 0);
    endtask

    task automatic t_load_all;
        int lc, hc; logic [3:0] sm; bit ld, cm, db;
        for (int i = 0; i < 4; i++) begin
            do_write(4'(LB + i), 8'h10 + 8'(i), lc, hc, sm, ld, cm, db);
            chk(sm == 4'(1 << i) && ld && !cm, "R2 select", sm, 1 << i);
            chk(lc == W_EXP, "R4 width", lc, W_EXP);
            chk(hc == H_EXP, "R5 hold", hc, H_EXP);
            chk(!db, "R10 data stable", db, 0);
            chk(dac_data == 8'h10 + 8'(i), "R5 data kept", dac_data, 8'h10 + i);
            chk(in_reg[i] == 8'h10 + 8'(i), "R2 latched", in_reg[i], 8'h10 + i);
        end
        chk(dac_pending == 4'hF, "R8 pending set", dac_pending, 15);
        do_write(4'(CA), 8'h00, lc, hc, sm, ld, cm, db);
        chk(cm && sm == 0 && !ld, "R3 commit strobe", {cm, sm}, 16);
        chk(lc == W_EXP && hc == H_EXP, "R4 commit width", lc, W_EXP);
        chk(dac_pending == 0, "R8 pending clear", dac_pending, 0);
        chk(dac_data == 8'h13, "R5 data unchanged by commit", dac_data, 8'h13);
        for (int i = 0; i < 4; i++)
            chk(out_reg[i] == 8'h10 + 8'(i), "R8 all updated", out_reg[i], 8'h10 + i);
    endtask

    task automatic t_partial_update;
        int lc, hc; logic [3:0] sm; bit ld, cm, db;
        do_write(4'(LB + 0), 8'hA5, lc, hc, sm, ld, cm, db);
        do_write(4'(LB + 2), 8'h5A, lc, hc, sm, ld, cm, db);
        chk(dac_pending == 4'b0101, "R8 pending partial", dac_pending, 5);
        chk(out_reg[0] == 8'h10, "R8 no update before commit", out_reg[0], 16);
        do_write(4'(CA), 8'hFF, lc, hc, sm, ld, cm, db);
        chk(out_reg[0] == 8'hA5 && out_reg[2] == 8'h5A, "R8 loaded updated",
            {out_reg[0], out_reg[2]}, 16'hA55A);
        chk(out_reg[1] == 8'h11 && out_reg[3] == 8'h13, "R8 others unchanged",
            {out_reg[1], out_reg[3]}, 16'h1113);
    endtask

    task automatic t_unmapped;
        int lc, hc; logic [3:0] sm; bit ld, cm, db;
        do_write(4'd0, 8'h99, lc, hc, sm, ld, cm, db);
        chk(lc == 0 && hc == 0 && bus_ready, "R7 no wait", lc + hc, 0);
        chk(sm == 0 && !ld && !cm, "R7 no strobe", sm, 0);
        do_write(4'd9, 8'h98, lc, hc, sm, ld, cm, db);
        chk(lc == 0 && hc == 0 && sm == 0 && !ld && !cm, "R7 addr 9", lc + hc, 0);
        chk(dac_data == 8'h5A, "R5 data after unmapped", dac_data, 8'h5A);
    endtask

    task automatic t_freeze;
        int lc, hc; logic [3:0] sm; bit ld, cm, db;
        do_write(4'(LB + 3), 8'h3C, lc, hc, sm, ld, cm, db);
        freeze = 1'b1;
        @(negedge clk);
        chk(latch_en == 0, "R9 latch off", latch_en, 0);
        do_write(4'(LB + 1), 8'h77, lc, hc, sm, ld, cm, db);
        chk(lc == 0 && hc == 0 && sm == 0 && !ld, "R9 frozen no strobe", lc + hc, 0);
        chk(dac_pending == 4'b1000, "R9 pending unchanged", dac_pending, 8);
        chk(in_reg[1] == 8'h11, "R9 input reg kept", in_reg[1], 8'h11);
        freeze = 1'b0;
        @(negedge clk);
        chk(latch_en == 1, "R9 latch on", latch_en, 1);
        do_write(4'(CA), 8'h00, lc, hc, sm, ld, cm, db);
        chk(out_reg[3] == 8'h3C && out_reg[1] == 8'h11, "R8 commit after freeze",
            {out_reg[3], out_reg[1]}, 16'h3C11);
    endtask

    task automatic t_busy_ignore;
        int lows = 0, stray = 0, busy = 0;
        while (!bus_ready) @(negedge clk);
        bus_addr = 4'(LB + 2); bus_wdata = 8'hC3; bus_wr = 1'b1;
        @(negedge clk);
        bus_addr = 4'(LB + 0); bus_wdata = 8'h0F;
        for (int k = 0; k < 10; k++) begin
            if (bus_ready) stray++;
            if (!conv_sel_n[0]) stray++;
            if (dac_data != 8'hC3) stray++;
            @(negedge clk);
        end
        bus_wr = 1'b0;
        busy = 10;
        while (!bus_ready) begin
            busy++;
            if (!load_stb_n) lows++;
            @(negedge clk);
        end
        chk(stray == 0, "R6 request while busy ignored", stray, 0);
        chk(busy == W_EXP + H_EXP, "R6 ready low span", busy, W_EXP + H_EXP);
        chk(dac_pending == 4'b0100, "R6 only first write counted", dac_pending, 4);
        chk(in_reg[0] == 8'hA5, "R6 no stray load", in_reg[0], 8'hA5);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_all();
        t_partial_update();
        t_unmapped();
        t_freeze();
        t_busy_ignore();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule